// File: doc/BRIEF.md
# Bus Signal-Free-Time Gate

This block sits in the transmit side of a controller for a shared single-wire, open-drain control bus. Before a node may start a new message, the line must have stayed idle (high) for a minimum time. The block measures that idle time in half-bit-period ticks and raises a transmit-permit flag once the required time has passed. Bit encoding, arbitration and reception are handled elsewhere.

The required idle time comes from a 3-bit setting. A nonzero setting `n` asks for `n - 0.5` nominal bit periods, which is `2n - 1` half-period ticks. A zero setting selects a default that depends on what happened last on the bus: a retry after a failed transmit, a new initiator after another node's message, or a back-to-back send by this node. A start-option bit picks whether timing begins on a software start-of-message request or automatically at the end of any message.

Top module: `sftg_gate`

## Requirements
- R1: After reset `txPermit` is 0 and stays 0 until a timing window has been started and completed.
- R2: With `sftSel` = n (1..7), `txPermit` rises after exactly `2n-1` qualifying `halfTick` pulses with the bus high, and not after `2n-2`.
- R3: With `sftSel` = 0 and the last recorded event being reset or a receive end (`rxEnd`), the window is 9 half ticks.
- R4: With `sftSel` = 0 and the last recorded event a failed transmit (`txFail`), the window is 5 half ticks; `txFail` takes precedence over `txEnd` in the same cycle.
- R5: With `sftSel` = 0 and the last recorded event a successful transmit end (`txEnd`), the window is 13 half ticks.
- R6: Any cycle with `busLevel` = 0 while timing restarts the idle count from zero.
- R7: With `autoStart` = 0, only `somReq` starts timing; `txEnd`, `txFail` and `rxEnd` do not.
- R8: With `autoStart` = 1, `txEnd`, `txFail` or `rxEnd` starts timing; `somReq` does not.
- R9: Once high, `txPermit` stays high, even if the bus goes low, until `txStart` is pulsed, which clears it on the next clock.
- R10: `enable` = 0 clears `txPermit` on the next clock and abandons any count in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable; low clears permit and timing |
| busLevel | input | 1 | Sampled bus level, 1 = idle/high |
| halfTick | input | 1 | One-cycle pulse every half nominal bit period |
| sftSel | input | 3 | Idle-time setting, 0 = history-dependent default |
| autoStart | input | 1 | 1 = start timing at end of any message, 0 = on somReq |
| somReq | input | 1 | Software start-of-message request strobe |
| txStart | input | 1 | Strobe: a transmission has begun |
| txEnd | input | 1 | Strobe: own transmission ended successfully |
| txFail | input | 1 | Strobe: own transmission ended in failure |
| rxEnd | input | 1 | Strobe: a received message ended |
| txPermit | output | 1 | Transmission may begin |

## Verification
Programmed settings 1, 3 and 7 are run with the tick count stopped one short of and exactly at the window, which separates an off-by-one or a whole-period error in the half-step arithmetic. The default setting is run after a failure, a successful send and a received message, which tells the three history-dependent windows apart and shows which event last updated the history. Each arming strobe is applied in both option states to show that only the selected one starts timing, a single low bus cycle is placed one tick before expiry to expose a count that is not cleared, and disable and transmit-start strobes show how the permit is released.

// File: rtl/sftg_pkg.sv
package sftg_pkg;

  // Last bus event that selects the default idle window
  typedef enum logic [1:0] {
    HIST_NEW   = 2'd0,
    HIST_RETRY = 2'd1,
    HIST_SAME  = 2'd2
  } histKind_t;

  // Strobes from control to the idle counter
  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } cntCtrl_t;

endpackage

// File: rtl/sftg_datapath.sv
module sftg_datapath
  import sftg_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int CNT_W        = 4,
  parameter int RETRY_HALVES = 5,
  parameter int NEW_HALVES   = 9,
  parameter int SAME_HALVES  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctrl,
  input  logic [SEL_W-1:0] sftSel,
  input  histKind_t        hist,
  output logic             reached
);

  logic [CNT_W-1:0] idleCnt;
  logic [CNT_W-1:0] threshold;

  // Required idle time in half-bit ticks
  always_comb begin
    if (sftSel == '0) begin
      unique case (hist)
        HIST_RETRY: threshold = CNT_W'(RETRY_HALVES);
        HIST_SAME:  threshold = CNT_W'(SAME_HALVES);
        default:    threshold = CNT_W'(NEW_HALVES);
      endcase
    end else begin
      // n - 0.5 periods = 2n - 1 half periods
      threshold = CNT_W'({sftSel, 1'b0}) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (ctrl.clrCnt) begin
      idleCnt <= '0;
    end else if (ctrl.cntEn) begin
      idleCnt <= idleCnt + CNT_W'(1);
    end
  end

  assign reached = (idleCnt >= threshold);

endmodule

// File: rtl/sftg_control.sv
module sftg_control
  import sftg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      busLevel,
  input  logic      halfTick,
  input  logic      autoStart,
  input  logic      somReq,
  input  logic      txStart,
  input  logic      txEnd,
  input  logic      txFail,
  input  logic      rxEnd,
  input  logic      reached,
  output cntCtrl_t  ctrl,
  output histKind_t hist,
  output logic      txPermit
);

  logic armed;
  logic msgEnd;
  logic startEv;

  assign msgEnd  = txEnd | txFail | rxEnd;
  assign startEv = (autoStart ? msgEnd : somReq) & !txPermit;

  always_comb begin
    ctrl.clrCnt = !enable | startEv | !busLevel | txStart;
    ctrl.cntEn  = armed & halfTick & busLevel & !reached;
  end

  // Timing window and permit flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed    <= 1'b0;
      txPermit <= 1'b0;
    end else if (!enable || txStart) begin
      armed    <= 1'b0;
      txPermit <= 1'b0;
    end else if (startEv) begin
      armed    <= 1'b1;
    end else if (armed && reached) begin
      armed    <= 1'b0;
      txPermit <= 1'b1;
    end
  end

  // History of the last bus event, failure has precedence
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= HIST_NEW;
    end else if (txFail) begin
      hist <= HIST_RETRY;
    end else if (txEnd) begin
      hist <= HIST_SAME;
    end else if (rxEnd) begin
      hist <= HIST_NEW;
    end
  end

endmodule

// File: rtl/sftg_gate.sv
module sftg_gate
  import sftg_pkg::*;
#(
  parameter int SEL_W        = 3,
  parameter int RETRY_HALVES = 5,
  parameter int NEW_HALVES   = 9,
  parameter int SAME_HALVES  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             busLevel,
  input  logic             halfTick,
  input  logic [SEL_W-1:0] sftSel,
  input  logic             autoStart,
  input  logic             somReq,
  input  logic             txStart,
  input  logic             txEnd,
  input  logic             txFail,
  input  logic             rxEnd,
  output logic             txPermit
);

  localparam int PROG_MAX = 2 * ((2 ** SEL_W) - 1) - 1;
  localparam int DFLT_MAX = (SAME_HALVES > NEW_HALVES)
                            ? ((SAME_HALVES > RETRY_HALVES) ? SAME_HALVES : RETRY_HALVES)
                            : ((NEW_HALVES > RETRY_HALVES) ? NEW_HALVES : RETRY_HALVES);
  localparam int ALL_MAX  = (PROG_MAX > DFLT_MAX) ? PROG_MAX : DFLT_MAX;
  localparam int CNT_W    = $clog2(ALL_MAX + 1);

  cntCtrl_t  cntCtrl;
  histKind_t hist;
  logic      reached;

  sftg_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .busLevel (busLevel),
    .halfTick (halfTick),
    .autoStart(autoStart),
    .somReq   (somReq),
    .txStart  (txStart),
    .txEnd    (txEnd),
    .txFail   (txFail),
    .rxEnd    (rxEnd),
    .reached  (reached),
    .ctrl     (cntCtrl),
    .hist     (hist),
    .txPermit (txPermit)
  );

  sftg_datapath #(
    .SEL_W       (SEL_W),
    .CNT_W       (CNT_W),
    .RETRY_HALVES(RETRY_HALVES),
    .NEW_HALVES  (NEW_HALVES),
    .SAME_HALVES (SAME_HALVES)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (cntCtrl),
    .sftSel (sftSel),
    .hist   (hist),
    .reached(reached)
  );

endmodule

// File: rtl/sftg_gate_chk.sv
module sftg_gate_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic txStart,
  input logic txPermit
);

  // R9: a transmission start releases the permit
  p_drop_on_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (enable && txStart) |=> !txPermit);

  // R9: permit is held while enabled and no transmission starts
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (txPermit && enable && !txStart) |=> txPermit);

  // R10: disabling clears the permit
  p_disable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !txPermit);

  // R10: permit can only be granted while enabled
  p_rise_enabled_r10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPermit) |-> $past(enable));

endmodule

bind sftg_gate sftg_gate_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .txStart (txStart),
  .txPermit(txPermit)
);

// File: tb/sftg_gate_tb.sv
`timescale 1ns/1ps
module sftg_gate_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       busLevel = 1'b1;
  logic       halfTick = 1'b0;
  logic [2:0] sftSel = 3'd0;
  logic       autoStart = 1'b0;
  logic       somReq = 1'b0;
  logic       txStart = 1'b0;
  logic       txEnd = 1'b0;
  logic       txFail = 1'b0;
  logic       rxEnd = 1'b0;
  logic       txPermit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sftg_gate u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .busLevel (busLevel),
    .halfTick (halfTick),
    .sftSel   (sftSel),
    .autoStart(autoStart),
    .somReq   (somReq),
    .txStart  (txStart),
    .txEnd    (txEnd),
    .txFail   (txFail),
    .rxEnd    (rxEnd),
    .txPermit (txPermit)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (txPermit !== exp) begin
      errors++;
      $display("FAIL %s: txPermit actual %b expected %b", req, txPermit, exp);
    end
  endtask

  // one half-bit tick, sampled two edges later at a falling edge
  task automatic tick();
    @(negedge clk) halfTick = 1'b1;
    @(negedge clk) halfTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulseSom();   @(negedge clk) somReq = 1'b1;  @(negedge clk) somReq = 1'b0;  endtask
  task automatic pulseStart(); @(negedge clk) txStart = 1'b1; @(negedge clk) txStart = 1'b0; endtask
  task automatic pulseEnd();   @(negedge clk) txEnd = 1'b1;   @(negedge clk) txEnd = 1'b0;   endtask
  task automatic pulseFail();  @(negedge clk) txFail = 1'b1;  @(negedge clk) txFail = 1'b0;  endtask
  task automatic pulseRx();    @(negedge clk) rxEnd = 1'b1;   @(negedge clk) rxEnd = 1'b0;   endtask

  // run a started window of w half ticks: low just before, high at w
  task automatic window(input string req, input int w);
    ticks(w - 1);
    chk(req, 1'b0);
    tick();
    chk(req, 1'b1);
    pulseStart();
    chk("R9", 1'b0);
  endtask

  task automatic t_reset();
    chk("R1", 1'b0);
    ticks(3);
    chk("R1", 1'b0);
  endtask

  task automatic t_programmed(input int n);
    autoStart = 1'b0;
    sftSel = 3'(n);
    pulseSom();
    window("R2", 2 * n - 1);
  endtask

  task automatic t_default_new();
    autoStart = 1'b0;
    sftSel = 3'd0;
    pulseSom();
    window("R3", 9);
  endtask

  task automatic t_retry_and_manual_option();
    autoStart = 1'b0;
    sftSel = 3'd0;
    pulseFail();
    ticks(15);
    chk("R7", 1'b0);
    pulseRx();
    pulseEnd();
    ticks(15);
    chk("R7", 1'b0);
    // last event was txEnd; both strobes together: failure wins
    @(negedge clk) begin txEnd = 1'b1; txFail = 1'b1; end
    @(negedge clk) begin txEnd = 1'b0; txFail = 1'b0; end
    pulseSom();
    window("R4", 5);
  endtask

  task automatic t_same();
    autoStart = 1'b0;
    sftSel = 3'd0;
    pulseEnd();
    pulseSom();
    window("R5", 13);
  endtask

  task automatic t_auto_option();
    autoStart = 1'b1;
    sftSel = 3'd0;
    pulseSom();
    ticks(15);
    chk("R8", 1'b0);
    pulseRx();
    window("R8", 9);
    pulseEnd();
    window("R8", 13);
    pulseFail();
    window("R8", 5);
    autoStart = 1'b0;
  endtask

  task automatic t_bus_low();
    autoStart = 1'b0;
    sftSel = 3'd3;
    pulseSom();
    ticks(4);
    @(negedge clk) busLevel = 1'b0;
    @(negedge clk) busLevel = 1'b1;
    ticks(4);
    chk("R6", 1'b0);
    tick();
    chk("R6", 1'b1);
    busLevel = 1'b0;
    ticks(3);
    chk("R9", 1'b1);
    busLevel = 1'b1;
    ticks(2);
    chk("R9", 1'b1);
    pulseStart();
    chk("R9", 1'b0);
  endtask

  task automatic t_disable();
    autoStart = 1'b0;
    sftSel = 3'd2;
    pulseSom();
    ticks(3);
    chk("R10", 1'b1);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    chk("R10", 1'b0);
    ticks(5);
    chk("R10", 1'b0);
    pulseSom();
    ticks(2);
    @(negedge clk) enable = 1'b0;
    @(negedge clk) enable = 1'b1;
    ticks(5);
    chk("R10", 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk) enable = 1'b1;
    @(negedge clk);
    t_reset();
    t_programmed(1);
    t_programmed(3);
    t_programmed(7);
    t_default_new();
    t_retry_and_manual_option();
    t_same();
    t_auto_option();
    t_bus_low();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule